// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block keeps the interrupt enable mask of a network controller and turns it, together with a pending-cause vector, into one level interrupt request. Software never writes the mask directly. It writes ones to an enable port to turn sources on. It writes ones to a separate disable port to turn them off. Zeros written to either port change nothing. The enable address reads back the current mask.

The pending-cause vector is an input from the event logic elsewhere in the controller. The request output rises whenever an enabled source has a pending cause. A control input arms a moderation-timer reload. When it is high, an enable write that sets every defined source produces a single-cycle reload pulse toward the interrupt timers. Clearing causes and running the timers belong to other blocks.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A write on the enable port sets every defined mask bit whose write-data bit is 1. `mask_rdata` shows the new mask from the clock edge that takes the write.
- R2: Write-data bits of 0 on the enable port leave the matching mask bits unchanged. An enable write can never clear a mask bit.
- R3: A write on the disable port clears every mask bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: When both ports write the same bit in the same cycle, that bit ends up cleared.
- R5: Every mask bit is 0 after reset. The reserved positions 3, 5, 8, 10 to 14, 19 and 25 to 31 are never set and always read 0. The defined positions are 0, 1, 2, 4, 6, 7, 9, 15, 16, 17, 18, 20 to 24, which is the value 0x01F782D7.
- R6: `irq_o` is registered. It is 1 in the cycle after a clock edge at which (mask & cause) was nonzero, and 0 after an edge at which it was zero.
- R7: A pending cause on a bit whose mask is 0, including a reserved bit, never raises `irq_o`.
- R8: With `tmr_clr_en` at 1, an enable write whose data has all defined bits at 1 drives `tmr_reload_o` high for exactly the one cycle after that edge. Reserved data bits do not matter.
- R9: `tmr_reload_o` stays 0 when `tmr_clr_en` is 0, and when any defined bit of the enable write data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_we | input | 1 | Enable-port write strobe |
| set_wdata | input | 32 | Enable-port write data, ones enable |
| clr_we | input | 1 | Disable-port write strobe |
| clr_wdata | input | 32 | Disable-port write data, ones disable |
| mask_rdata | output | 32 | Current mask, read through the enable address |
| cause_i | input | 32 | Pending interrupt causes |
| tmr_clr_en | input | 1 | Arms the timer reload on an all-ones enable write |
| irq_o | output | 1 | Level interrupt request |
| tmr_reload_o | output | 1 | One-cycle moderation-timer reload pulse |

## Verification
The bench goes after these corner cases:
- An enable write of zeros after sources are on. A design that treats the port as a plain register would drop the mask.
- Both ports hitting one bit in one cycle. The wrong priority leaves the bit enabled.
- Writes of all ones, which probe the reserved positions. A missing filter lets those bits show up in the read-back and in the request.
- The reload pulse with the arm input low, and with exactly one defined bit missing from the data. A loose comparison would fire a spurious reload. A reserved-bit-sensitive compare would miss the valid 0x01F782D7 write.
- The request timing against a cause change, which exposes an unregistered or doubly registered output.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int IRQM_W = 32;

    // Positions of the defined interrupt sources
    localparam int SRC_TX_WB      = 0;
    localparam int SRC_TX_EMPTY   = 1;
    localparam int SRC_LINK       = 2;
    localparam int SRC_RX_MINTHR  = 4;
    localparam int SRC_RX_OVRN    = 6;
    localparam int SRC_RX_TMR     = 7;
    localparam int SRC_MDIO_DONE  = 9;
    localparam int SRC_TX_LOWTHR  = 15;
    localparam int SRC_RX_SMALL   = 16;
    localparam int SRC_RX_ACK     = 17;
    localparam int SRC_MGMT       = 18;
    localparam int SRC_QUEUE_BASE = 20;
    localparam int SRC_QUEUE_CNT  = 4;
    localparam int SRC_OTHER      = 24;

    function automatic logic [IRQM_W-1:0] build_valid();
        logic [IRQM_W-1:0] v;
        v = '0;
        v[SRC_TX_WB]     = 1'b1;
        v[SRC_TX_EMPTY]  = 1'b1;
        v[SRC_LINK]      = 1'b1;
        v[SRC_RX_MINTHR] = 1'b1;
        v[SRC_RX_OVRN]   = 1'b1;
        v[SRC_RX_TMR]    = 1'b1;
        v[SRC_MDIO_DONE] = 1'b1;
        v[SRC_TX_LOWTHR] = 1'b1;
        v[SRC_RX_SMALL]  = 1'b1;
        v[SRC_RX_ACK]    = 1'b1;
        v[SRC_MGMT]      = 1'b1;
        for (int q = 0; q < SRC_QUEUE_CNT; q++) begin
            v[SRC_QUEUE_BASE + q] = 1'b1;
        end
        v[SRC_OTHER]     = 1'b1;
        return v;
    endfunction

    localparam logic [IRQM_W-1:0] IRQM_VALID = build_valid();

    typedef struct packed {
        logic [IRQM_W-1:0] mask;
    } mask_st_t;

    typedef struct packed {
        logic irq;
    } req_st_t;

    typedef struct packed {
        logic pulse;
    } rld_st_t;

endpackage

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg
    import irqm_pkg::*;
#(
    parameter int               W     = IRQM_W,
    parameter logic [W-1:0]     VALID = IRQM_VALID[W-1:0]
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_wdata,
    input  logic         clr_we,
    input  logic [W-1:0] clr_wdata,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_d;
    logic [W-1:0] mask_q;

    // Per-bit next state: set first, clear afterwards so clear wins.
    // Reserved positions are tied to zero.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (VALID[b]) begin : g_live
            always_comb begin
                mask_d[b] = mask_q[b];
                if (set_we && set_wdata[b]) begin
                    mask_d[b] = 1'b1;
                end
                if (clr_we && clr_wdata[b]) begin
                    mask_d[b] = 1'b0;
                end
            end
        end else begin : g_rsvd
            assign mask_d[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/irqm_req_gen.sv
module irqm_req_gen
    import irqm_pkg::*;
#(
    parameter int W = IRQM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] cause_i,
    output logic         irq_o
);

    req_st_t st_d;
    req_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(mask_i & cause_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/irqm_reload_det.sv
module irqm_reload_det
    import irqm_pkg::*;
#(
    parameter int           W     = IRQM_W,
    parameter logic [W-1:0] VALID = IRQM_VALID[W-1:0]
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_wdata,
    input  logic         arm_i,
    output logic         pulse_o
);

    rld_st_t st_d;
    rld_st_t st_q;
    logic    full_write;

    // Only defined positions take part in the all-ones compare
    assign full_write = ((set_wdata & VALID) == VALID);

    always_comb begin
        st_d       = st_q;
        st_d.pulse = set_we && arm_i && full_write;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqm_pkg::*;
#(
    parameter int           W     = IRQM_W,
    parameter logic [W-1:0] VALID = IRQM_VALID[W-1:0]
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_wdata,
    input  logic         clr_we,
    input  logic [W-1:0] clr_wdata,
    output logic [W-1:0] mask_rdata,
    input  logic [W-1:0] cause_i,
    input  logic         tmr_clr_en,
    output logic         irq_o,
    output logic         tmr_reload_o
);

    logic [W-1:0] mask_w;

    irqm_mask_reg #(.W(W), .VALID(VALID)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (set_we),
        .set_wdata (set_wdata),
        .clr_we    (clr_we),
        .clr_wdata (clr_wdata),
        .mask_o    (mask_w)
    );

    irqm_req_gen #(.W(W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_i  (mask_w),
        .cause_i (cause_i),
        .irq_o   (irq_o)
    );

    irqm_reload_det #(.W(W), .VALID(VALID)) u_rld (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_we    (set_we),
        .set_wdata (set_wdata),
        .arm_i     (tmr_clr_en),
        .pulse_o   (tmr_reload_o)
    );

    assign mask_rdata = mask_w;

endmodule

// File: rtl/irqm_checker.sv
module irqm_checker #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         set_we,
    input logic [W-1:0] set_wdata,
    input logic         clr_we,
    input logic [W-1:0] clr_wdata,
    input logic [W-1:0] mask_rdata,
    input logic [W-1:0] cause_i,
    input logic         tmr_clr_en,
    input logic         irq_o,
    input logic         tmr_reload_o
);

    p_set_enables_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=>
            ((mask_rdata & $past(set_wdata & VALID)) == $past(set_wdata & VALID)));

    p_no_drop_without_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((mask_rdata & $past(mask_rdata)) == $past(mask_rdata)));

    p_clear_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask_rdata & $past(clr_wdata)) == '0));

    p_clear_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=>
            (mask_rdata == ($past(mask_rdata) & ~$past(clr_wdata))));

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata & ~VALID) == '0);

    p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (irq_o == $past(|(mask_rdata & cause_i))));

    p_reload_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && tmr_clr_en && ((set_wdata & VALID) == VALID)) |=> tmr_reload_o);

    p_reload_only_when_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 ($past(!tmr_clr_en || !set_we) |-> !tmr_reload_o));

endmodule

bind irq_mask_ctrl irqm_checker #(.W(W), .VALID(VALID)) u_irqm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_we       (set_we),
    .set_wdata    (set_wdata),
    .clr_we       (clr_we),
    .clr_wdata    (clr_wdata),
    .mask_rdata   (mask_rdata),
    .cause_i      (cause_i),
    .tmr_clr_en   (tmr_clr_en),
    .irq_o        (irq_o),
    .tmr_reload_o (tmr_reload_o)
);

// File: tb/test_irq_mask_ctrl.sv
`timescale 1ns/1ps
module test_irq_mask_ctrl;

    localparam logic [31:0] DEF = 32'h01F7_82D7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_we = 1'b0;
    logic [31:0] set_wdata = '0;
    logic        clr_we = 1'b0;
    logic [31:0] clr_wdata = '0;
    logic [31:0] mask_rdata;
    logic [31:0] cause_i = '0;
    logic        tmr_clr_en = 1'b0;
    logic        irq_o;
    logic        tmr_reload_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_mask_ctrl i_irq_mask_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_we       (set_we),
        .set_wdata    (set_wdata),
        .clr_we       (clr_we),
        .clr_wdata    (clr_wdata),
        .mask_rdata   (mask_rdata),
        .cause_i      (cause_i),
        .tmr_clr_en   (tmr_clr_en),
        .irq_o        (irq_o),
        .tmr_reload_o (tmr_reload_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Writes happen on the posedge inside; returns at the following negedge
    task automatic wr(input bit s, input logic [31:0] sd, input bit c, input logic [31:0] cd);
        @(negedge clk);
        set_we = s; set_wdata = sd; clr_we = c; clr_wdata = cd;
        @(negedge clk);
        set_we = 1'b0; clr_we = 1'b0; set_wdata = '0; clr_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check(mask_rdata == 32'h0, "R5 reset mask", mask_rdata, 32'h0);
        check(irq_o == 1'b0, "R6 reset irq", {31'b0, irq_o}, 32'h0);
        check(tmr_reload_o == 1'b0, "R8 reset pulse", {31'b0, tmr_reload_o}, 32'h0);
    endtask

    task automatic t_set();
        wr(1, 32'h0000_0005, 0, '0);
        check(mask_rdata == 32'h0000_0005, "R1 first set", mask_rdata, 32'h5);
        wr(1, 32'h0010_0200, 0, '0);
        check(mask_rdata == 32'h0010_0205, "R1 accumulate", mask_rdata, 32'h0010_0205);
    endtask

    task automatic t_zero_keeps();
        wr(1, 32'h0, 0, '0);
        check(mask_rdata == 32'h0010_0205, "R2 zero write keeps", mask_rdata, 32'h0010_0205);
        wr(0, 32'h0, 1, 32'h0);
        check(mask_rdata == 32'h0010_0205, "R3 zero clear keeps", mask_rdata, 32'h0010_0205);
    endtask

    task automatic t_clear();
        wr(0, '0, 1, 32'h0000_0004);
        check(mask_rdata == 32'h0010_0201, "R3 clear one bit", mask_rdata, 32'h0010_0201);
    endtask

    task automatic t_priority();
        wr(1, 32'h0100_0002, 1, 32'h0100_0001);
        check(mask_rdata == 32'h0010_0202, "R4 clear wins", mask_rdata, 32'h0010_0202);
    endtask

    task automatic t_reserved();
        wr(0, '0, 1, 32'hFFFF_FFFF);
        check(mask_rdata == 32'h0, "R3 clear all", mask_rdata, 32'h0);
        wr(1, 32'hFFFF_FFFF, 0, '0);
        check(mask_rdata == DEF, "R5 reserved filtered", mask_rdata, DEF);
        wr(0, '0, 1, 32'hFFFF_FFFF);
        wr(1, ~DEF, 0, '0);
        check(mask_rdata == 32'h0, "R5 reserved only write", mask_rdata, 32'h0);
    endtask

    task automatic t_irq();
        // mask 0: cause on everything must not request
        @(negedge clk); cause_i = 32'hFFFF_FFFF;
        @(negedge clk); @(negedge clk);
        check(irq_o == 1'b0, "R7 masked cause", {31'b0, irq_o}, 32'h0);
        // enable only reserved-free bit 4 with cause only on reserved bit 3
        @(negedge clk); cause_i = 32'h0000_0008;
        wr(1, 32'h0000_0010, 0, '0);
        @(negedge clk);
        check(irq_o == 1'b0, "R7 reserved cause", {31'b0, irq_o}, 32'h0);
        // cause on enabled bit: registered, visible after one edge
        @(negedge clk); cause_i = 32'h0000_0010;
        check(irq_o == 1'b0, "R6 not combinational", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check(irq_o == 1'b1, "R6 raise", {31'b0, irq_o}, 32'h1);
        // clear mask: edge k updates mask, edge k+1 drops irq
        @(negedge clk); clr_we = 1'b1; clr_wdata = 32'h0000_0010;
        @(negedge clk); clr_we = 1'b0; clr_wdata = '0;
        check(irq_o == 1'b1, "R6 one-cycle lag", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        check(irq_o == 1'b0, "R6 drop", {31'b0, irq_o}, 32'h0);
        cause_i = '0;
    endtask

    task automatic t_pulse();
        tmr_clr_en = 1'b1;
        @(negedge clk); set_we = 1'b1; set_wdata = 32'hFFFF_FFFF;
        @(negedge clk); set_we = 1'b0; set_wdata = '0;
        check(tmr_reload_o == 1'b1, "R8 pulse high", {31'b0, tmr_reload_o}, 32'h1);
        @(negedge clk);
        check(tmr_reload_o == 1'b0, "R8 pulse one cycle", {31'b0, tmr_reload_o}, 32'h0);
        @(negedge clk); set_we = 1'b1; set_wdata = DEF;
        @(negedge clk); set_we = 1'b0; set_wdata = '0;
        check(tmr_reload_o == 1'b1, "R8 defined-only ones", {31'b0, tmr_reload_o}, 32'h1);
        @(negedge clk); set_we = 1'b1; set_wdata = 32'hFFFF_FFFF & ~(32'h1 << 24);
        @(negedge clk); set_we = 1'b0; set_wdata = '0;
        check(tmr_reload_o == 1'b0, "R9 one defined bit zero", {31'b0, tmr_reload_o}, 32'h0);
        tmr_clr_en = 1'b0;
        @(negedge clk); set_we = 1'b1; set_wdata = 32'hFFFF_FFFF;
        @(negedge clk); set_we = 1'b0; set_wdata = '0;
        check(tmr_reload_o == 1'b0, "R9 not armed", {31'b0, tmr_reload_o}, 32'h0);
        check(mask_rdata == DEF, "R1 all set still enables", mask_rdata, DEF);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_set();
        t_zero_keeps();
        t_clear();
        t_priority();
        t_reserved();
        t_irq();
        t_pulse();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule